// File: doc/BRIEF.md
# DisplayPort link configuration selector

This block chooses the smallest link setup (lane count and per-lane symbol rate) that can carry a video mode. It takes the mode's pixel clock in kHz and three receiver capability fields: the capability revision byte, the advertised maximum rate code, and the low five bits of the advertised lane-count byte. A start pulse captures these inputs. The block then examines one candidate configuration per clock cycle, in a fixed order, and stops at the first one that fits.

When the search ends, the block pulses `done` for one cycle. With that pulse it reports whether a configuration was found, the chosen rate code and lane count, and the link symbol clock in kHz. The symbol clock is the value the pixel clock of the display pipe is adjusted to. Two qualifier flags come with the result. One says that the mode exceeds what the receiver can carry at all. The other says that the pixel clock is below the supported floor. The results stay unchanged until the next search finishes.

Top module: `dp_link_sel`

## Requirements
- R1: The required bandwidth is 3 × `pclk_khz`. A candidate fits when its symbol clock in kHz times its lane count is greater than or equal to that value, so an exact match fits.
- R2: Candidates are tried with lane count as the outer loop (1, then 2, then 4) and rate as the inner loop (low rate, then high rate). The first fitting candidate is the result.
- R3: On success, `rate_code` is 0x06 with `link_khz` = 162000 for the low rate, or 0x0A with `link_khz` = 270000 for the high rate. `lane_cnt` holds the lane count as a binary number (1, 2 or 4).
- R4: The lane limit is 4 when `cap_rev` < 0x11. When `cap_rev` ≥ 0x11, the lane limit is `cap_lanes` if that field is 1 or 2, and 4 for any other value of the field.
- R5: The high rate is tried only when `cap_rate` equals 0x0A. Any other value limits the search to the low rate.
- R6: When no candidate within the limits fits, `ok` is 0 and `rate_code`, `lane_cnt` and `link_khz` are all zero.
- R7: With `done`, `too_fast` is 1 exactly when 3 × `pclk_khz` exceeds the maximum symbol clock times the lane limit. `too_slow` is 1 exactly when `pclk_khz` < 10000.
- R8: `done` is high for exactly one cycle, n clock edges after the edge that samples `start`, where n is the number of candidates examined. Between `done` pulses all result outputs hold their values.
- R9: A `start` that arrives during a search abandons that search and begins a new one with the newly presented inputs. No `done` is produced for the abandoned search.
- R10: After reset, `done`, `ok`, `too_fast`, `too_slow`, `rate_code`, `lane_cnt` and `link_khz` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Captures the inputs and begins a search |
| pclk_khz | input | W | Mode pixel clock in kHz |
| cap_rev | input | 8 | Receiver capability revision |
| cap_rate | input | 8 | Advertised maximum rate code |
| cap_lanes | input | 5 | Low five bits of the advertised lane-count field |
| done | output | 1 | One-cycle search-complete pulse |
| ok | output | 1 | A fitting configuration was found |
| rate_code | output | 8 | Chosen rate code |
| lane_cnt | output | 3 | Chosen lane count |
| link_khz | output | W | Chosen link symbol clock in kHz |
| too_fast | output | 1 | Mode exceeds the receiver's ceiling |
| too_slow | output | 1 | Pixel clock below 10000 kHz |

## Verification
The bench model counts how many candidates the search must visit, from 1 to 6. It then expects `done` and the new results exactly that many edges after the edge that sampled `start`, with every output unchanged on all other cycles. The bench drives inputs and samples outputs on the falling edge. After each rising edge the model advances one step, then the whole output set is compared. This means a pulse that arrives one cycle early or late, or a result that changes outside its pulse, is caught on the cycle it happens. A restart partway through a search resets the model's countdown in the same step as the design.

// File: rtl/dpl_pkg.sv
package dpl_pkg;
  localparam logic [7:0]  RATE_LO_CODE = 8'h06;
  localparam logic [7:0]  RATE_HI_CODE = 8'h0A;
  localparam logic [31:0] LO_KHZ       = 32'd162000;
  localparam logic [31:0] HI_KHZ       = 32'd270000;

  typedef enum logic {ST_IDLE, ST_SRCH} sel_st_e;

  function automatic logic [31:0] rate_khz(input logic hi);
    return hi ? HI_KHZ : LO_KHZ;
  endfunction
endpackage

// File: rtl/dpl_cap_limits.sv
module dpl_cap_limits #(
  parameter logic [7:0] REV_MIN = 8'h11
) (
  input  logic [7:0] rev,
  input  logic [7:0] rate,
  input  logic [4:0] lanes,
  output logic [1:0] max_li,
  output logic       max_hi
);
  // lane index: 0 -> 1 lane, 1 -> 2 lanes, 2 -> 4 lanes
  always_comb begin
    max_li = 2'd2;
    if (rev >= REV_MIN) begin
      case (lanes)
        5'd1:    max_li = 2'd0;
        5'd2:    max_li = 2'd1;
        default: max_li = 2'd2;
      endcase
    end
  end

  assign max_hi = (rate == dpl_pkg::RATE_HI_CODE);
endmodule

// File: rtl/dpl_fit_eval.sv
module dpl_fit_eval #(
  parameter int W = 32
) (
  input  logic [W-1:0] pclk,
  input  logic [1:0]   li,
  input  logic         hi,
  output logic         fit
);
  logic [W-1:0] req;
  logic [W-1:0] avail;

  assign req   = pclk + (pclk << 1);
  assign avail = W'(dpl_pkg::rate_khz(hi)) << li;
  assign fit   = (avail >= req);
endmodule

// File: rtl/dpl_search.sv
module dpl_search #(
  parameter int          W        = 32,
  parameter logic [31:0] SLOW_KHZ = 32'd10000
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         start,
  input  logic [W-1:0] pclk_i,
  input  logic [1:0]   max_li_i,
  input  logic         max_hi_i,
  input  logic         fit_i,
  input  logic         fit_max_i,
  output logic [W-1:0] pclk_q,
  output logic [1:0]   cand_li,
  output logic         cand_hi,
  output logic [1:0]   lim_li,
  output logic         lim_hi,
  output logic         done,
  output logic         ok,
  output logic [7:0]   rate_code,
  output logic [2:0]   lane_cnt,
  output logic [W-1:0] link_khz,
  output logic         too_fast,
  output logic         too_slow
);
  import dpl_pkg::*;

  sel_st_e      st_q, st_n;
  logic [1:0]   li_n;
  logic         hi_n;
  logic         fin, found;
  logic         done_n, ok_n, fast_n, slow_n;
  logic [7:0]   code_n;
  logic [2:0]   lanes_n;
  logic [W-1:0] link_n;

  // next-state: one candidate per cycle, rate inner, lanes outer
  always_comb begin
    st_n  = st_q;
    li_n  = cand_li;
    hi_n  = cand_hi;
    fin   = 1'b0;
    found = 1'b0;
    if (start) begin
      st_n = ST_SRCH;
      li_n = 2'd0;
      hi_n = 1'b0;
    end else if (st_q == ST_SRCH) begin
      if (fit_i) begin
        fin   = 1'b1;
        found = 1'b1;
      end else if (!cand_hi && lim_hi) begin
        hi_n = 1'b1;
      end else if (cand_li < lim_li) begin
        li_n = cand_li + 2'd1;
        hi_n = 1'b0;
      end else begin
        fin = 1'b1;
      end
    end
    if (fin) st_n = ST_IDLE;
  end

  // result computation for the finishing cycle
  always_comb begin
    done_n  = fin;
    ok_n    = found;
    code_n  = found ? (cand_hi ? RATE_HI_CODE : RATE_LO_CODE) : 8'd0;
    lanes_n = found ? (3'b001 << cand_li) : 3'd0;
    link_n  = found ? W'(rate_khz(cand_hi)) : '0;
    fast_n  = !fit_max_i;
    slow_n  = (pclk_q < W'(SLOW_KHZ));
  end

  // control registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q    <= ST_IDLE;
      cand_li <= 2'd0;
      cand_hi <= 1'b0;
      done    <= 1'b0;
    end else begin
      st_q    <= st_n;
      cand_li <= li_n;
      cand_hi <= hi_n;
      done    <= done_n;
    end
  end

  // captured inputs, enabled by start
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pclk_q <= '0;
      lim_li <= 2'd0;
      lim_hi <= 1'b0;
    end else if (start) begin
      pclk_q <= pclk_i;
      lim_li <= max_li_i;
      lim_hi <= max_hi_i;
    end
  end

  // result bank, enabled only when a search finishes
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ok        <= 1'b0;
      rate_code <= 8'd0;
      lane_cnt  <= 3'd0;
      link_khz  <= '0;
      too_fast  <= 1'b0;
      too_slow  <= 1'b0;
    end else if (fin) begin
      ok        <= ok_n;
      rate_code <= code_n;
      lane_cnt  <= lanes_n;
      link_khz  <= link_n;
      too_fast  <= fast_n;
      too_slow  <= slow_n;
    end
  end
endmodule

// File: rtl/dp_link_sel.sv
module dp_link_sel #(
  parameter int          W        = 32,
  parameter logic [7:0]  REV_MIN  = 8'h11,
  parameter logic [31:0] SLOW_KHZ = 32'd10000
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         start,
  input  logic [W-1:0] pclk_khz,
  input  logic [7:0]   cap_rev,
  input  logic [7:0]   cap_rate,
  input  logic [4:0]   cap_lanes,
  output logic         done,
  output logic         ok,
  output logic [7:0]   rate_code,
  output logic [2:0]   lane_cnt,
  output logic [W-1:0] link_khz,
  output logic         too_fast,
  output logic         too_slow
);
  logic [1:0]   max_li;
  logic         max_hi;
  logic [W-1:0] pclk_q;
  logic [1:0]   cand_li, lim_li;
  logic         cand_hi, lim_hi;
  logic         fit, fit_max;

  dpl_cap_limits #(.REV_MIN(REV_MIN)) u_lim (
    .rev(cap_rev), .rate(cap_rate), .lanes(cap_lanes),
    .max_li(max_li), .max_hi(max_hi)
  );

  dpl_fit_eval #(.W(W)) u_cand (
    .pclk(pclk_q), .li(cand_li), .hi(cand_hi), .fit(fit)
  );

  dpl_fit_eval #(.W(W)) u_ceil (
    .pclk(pclk_q), .li(lim_li), .hi(lim_hi), .fit(fit_max)
  );

  dpl_search #(.W(W), .SLOW_KHZ(SLOW_KHZ)) u_srch (
    .clk(clk), .rst_n(rst_n), .start(start), .pclk_i(pclk_khz),
    .max_li_i(max_li), .max_hi_i(max_hi), .fit_i(fit), .fit_max_i(fit_max),
    .pclk_q(pclk_q), .cand_li(cand_li), .cand_hi(cand_hi),
    .lim_li(lim_li), .lim_hi(lim_hi),
    .done(done), .ok(ok), .rate_code(rate_code), .lane_cnt(lane_cnt),
    .link_khz(link_khz), .too_fast(too_fast), .too_slow(too_slow)
  );
endmodule

// File: rtl/dp_link_sel_chk.sv
module dp_link_sel_chk #(
  parameter int W = 32
) (
  input logic         clk,
  input logic         rst_n,
  input logic         start,
  input logic [W-1:0] pclk_khz,
  input logic [7:0]   cap_rev,
  input logic [7:0]   cap_rate,
  input logic [4:0]   cap_lanes,
  input logic         done,
  input logic         ok,
  input logic [7:0]   rate_code,
  input logic [2:0]   lane_cnt,
  input logic [W-1:0] link_khz,
  input logic         too_fast,
  input logic         too_slow
);
  logic [W+20:0] probe;
  assign probe = {pclk_khz, cap_rev, cap_rate, cap_lanes};

  // R8
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  // R8
  hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !done |-> $stable({ok, rate_code, lane_cnt, link_khz, too_fast, too_slow}));

  // R6
  fail_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !ok) |-> (rate_code == 8'd0 && lane_cnt == 3'd0 && link_khz == '0));

  // R7
  fast_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (done && ok) |-> !too_fast);

  // R3
  code_pair_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (done && ok) |-> ((rate_code == 8'h06 && link_khz == W'(162000)) ||
                      (rate_code == 8'h0A && link_khz == W'(270000))));

  // R3
  lane_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (done && ok) |-> ($countones(lane_cnt) == 1));

  // R9
  restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (start && probe == probe) |=> !done);
endmodule

bind dp_link_sel dp_link_sel_chk #(.W(W)) u_chk (
  .clk(clk), .rst_n(rst_n), .start(start), .pclk_khz(pclk_khz),
  .cap_rev(cap_rev), .cap_rate(cap_rate), .cap_lanes(cap_lanes),
  .done(done), .ok(ok), .rate_code(rate_code), .lane_cnt(lane_cnt),
  .link_khz(link_khz), .too_fast(too_fast), .too_slow(too_slow)
);

// File: tb/dp_link_sel_test.sv
`timescale 1ns/1ps
module dp_link_sel_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [31:0] pclk_khz = '0;
  logic [7:0]  cap_rev = '0, cap_rate = '0;
  logic [4:0]  cap_lanes = '0;
  logic        done, ok, too_fast, too_slow;
  logic [7:0]  rate_code;
  logic [2:0]  lane_cnt;
  logic [31:0] link_khz;

  int errors = 0;
  int checks = 0;

  always #2 clk = ~clk;

  dp_link_sel uut (
    .clk(clk), .rst_n(rst_n), .start(start), .pclk_khz(pclk_khz),
    .cap_rev(cap_rev), .cap_rate(cap_rate), .cap_lanes(cap_lanes),
    .done(done), .ok(ok), .rate_code(rate_code), .lane_cnt(lane_cnt),
    .link_khz(link_khz), .too_fast(too_fast), .too_slow(too_slow)
  );

  // reference model state
  bit          e_done, e_ok, e_fast, e_slow;
  logic [7:0]  e_code;
  logic [2:0]  e_lanes;
  logic [31:0] e_link;
  bit          p_ok, p_fast, p_slow;
  logic [7:0]  p_code;
  logic [2:0]  p_lanes;
  logic [31:0] p_link;
  int          p_n;
  int          rem = 0;

  task automatic check(input bit good, input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!good) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h at %0t", tag, act, exp, $time);
    end
  endtask

  // R1 R2 R4 R5 R7: behavioural plan of one search
  task automatic plan(input int pk);
    int maxl;
    bit hiok, found;
    longint req, lim;
    maxl = 4;
    if (cap_rev >= 8'h11 && (cap_lanes == 5'd1 || cap_lanes == 5'd2)) maxl = int'(cap_lanes);
    hiok = (cap_rate == 8'h0A);
    req = longint'(pk) * 3;
    found = 0; p_n = 0;
    p_ok = 0; p_code = 0; p_lanes = 0; p_link = 0;
    for (int l = 1; l <= maxl; l = l * 2) begin
      for (int r = 0; r <= (hiok ? 1 : 0); r++) begin
        longint k;
        k = (r == 1) ? 270000 : 162000;
        if (!found) begin
          p_n++;
          if (k * l >= req) begin
            found = 1; p_ok = 1;
            p_code = (r == 1) ? 8'h0A : 8'h06;
            p_lanes = 3'(l);
            p_link = 32'(k);
          end
        end
      end
    end
    lim = (hiok ? 270000 : 162000) * longint'(maxl);
    p_fast = (req > lim);
    p_slow = (pk < 10000);
  endtask

  task automatic cycle(input bit st, input string tag);
    start = st;
    @(posedge clk);
    @(negedge clk);
    start = 1'b0;
    if (st) begin
      rem = p_n; e_done = 0;
    end else if (rem > 0) begin
      rem--;
      e_done = (rem == 0);
      if (rem == 0) begin
        e_ok = p_ok; e_code = p_code; e_lanes = p_lanes; e_link = p_link;
        e_fast = p_fast; e_slow = p_slow;
      end
    end else e_done = 0;
    check(done === e_done, {tag, " done timing R8"}, 64'(done), 64'(e_done));
    check({ok, rate_code, lane_cnt, link_khz, too_fast, too_slow} ===
          {e_ok, e_code, e_lanes, e_link, e_fast, e_slow}, tag,
          64'({ok, rate_code, lane_cnt, link_khz, too_fast, too_slow}),
          64'({e_ok, e_code, e_lanes, e_link, e_fast, e_slow}));
  endtask

  task automatic run(input int pk, input logic [7:0] rv, input logic [7:0] rt,
                     input logic [4:0] ln, input string tag);
    pclk_khz = 32'(pk); cap_rev = rv; cap_rate = rt; cap_lanes = ln;
    plan(pk);
    cycle(1'b1, tag);
    repeat (8) cycle(1'b0, tag);
  endtask

  initial begin
    e_done = 0; e_ok = 0; e_fast = 0; e_slow = 0; e_code = 0; e_lanes = 0; e_link = 0;
    repeat (3) @(negedge clk);
    // R10 reset state
    check({done, ok, rate_code, lane_cnt, link_khz, too_fast, too_slow} === '0, "R10 reset",
          64'({done, ok, rate_code, lane_cnt, link_khz, too_fast, too_slow}), 64'd0);
    rst_n = 1'b1;
    cycle(1'b0, "R10 idle");

    run(25000,  8'h12, 8'h0A, 5'd4, "R1 one lane low");
    run(54000,  8'h12, 8'h0A, 5'd4, "R1 exact boundary");
    run(54001,  8'h12, 8'h0A, 5'd4, "R1 just above");
    run(100000, 8'h12, 8'h0A, 5'd4, "R2 two lanes low");
    run(170000, 8'h12, 8'h0A, 5'd4, "R3 two lanes high");
    run(360000, 8'h12, 8'h0A, 5'd4, "R8 six candidates");
    run(400000, 8'h12, 8'h0A, 5'd4, "R7 too fast");
    run(100000, 8'h11, 8'h14, 5'd4, "R5 bad rate code");
    run(100000, 8'h11, 8'h06, 5'd4, "R5 low rate code");
    run(200000, 8'h11, 8'h06, 5'd3, "R4 bad lane field");
    run(200000, 8'h10, 8'h06, 5'd1, "R4 old revision");
    run(100000, 8'h11, 8'h0A, 5'd2, "R4 two lane cap");
    run(60000,  8'h11, 8'h06, 5'd1, "R6 one lane fail");
    run(200000, 8'h11, 8'h0A, 5'd2, "R6 two lane fail");
    run(9999,   8'h12, 8'h06, 5'd4, "R7 too slow");
    run(10000,  8'h12, 8'h06, 5'd4, "R7 slow floor");

    // R9 restart partway through a long search
    pclk_khz = 32'd360000; cap_rev = 8'h12; cap_rate = 8'h0A; cap_lanes = 5'd4;
    plan(360000);
    cycle(1'b1, "R9 first start");
    cycle(1'b0, "R9 first start");
    cycle(1'b0, "R9 first start");
    run(25000, 8'h12, 8'h0A, 5'd4, "R9 restart");

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #(200000 * 4);
    errors++;
    checks++;
    $display("FAIL watchdog: actual=hung expected=finished");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule